// File: doc/BRIEF.md
# Serial Pad Configuration Chain

This block holds the electrical and routing setup of a row of I/O pads. Each pad has a cell with a 13-bit serial stage and a 13-bit live configuration word. The cells are wired in a daisy chain: the serial input of cell 0 comes from the chain's serial input pin, and each cell's serial output feeds the next cell. With the shift enable high, one bit moves one position per clock. A separate load strobe copies every serial stage into its live word at the same edge. Because of this, the pad controls never show partial data while a new bitstream is shifting in.

The live word drives the pad controls: a 3-bit drive mode, input disable, input buffer mode, trip-point select, slow slew, hold-over and three analog controls. It also holds a management-select bit and a stored output-disable bit. The management-select bit picks whether the pad's output data and output enable come from the management side or the user side. On the management side, an output-enable input held inactive hands the enable decision to the stored output-disable bit. This lets a pad with tied input and output still be switched by configuration. Pad input always returns to both sides.

Reset restores each cell to defaults set for each instance. The first `NUM_BIDIR` pads come up as strongly driven outputs. The other pads come up as inputs. All pads come up under management control.

Top module: `padcfg_chain`

## Requirements
- R1: A clock with `rst_n` low loads every cell's live word and serial stage with its defaults, visible after that edge. Pads below `NUM_BIDIR` get drive mode `BIDIR_DM` (default 3'b110) and stored output-disable 0. The other pads get `INPUT_DM` (default 3'b001) and output-disable 1. Every pad gets management select 1. All other control bits are 0.
- R2: With `shift_en` high, each clock moves `ser_in` into bit 0 of cell 0's stage and shifts every stage up one place. Stage bit 12 of cell k feeds bit 0 of cell k+1. `ser_out` is bit 12 of the last cell's stage, so a bit reaches `ser_out` 13×`NUM_PADS` clocks after it enters.
- R3: With `shift_en` low, no stage changes, whatever `ser_in` does.
- R4: The pad controls and the stored mode bits change only on a clock with `load` high or `rst_n` low. Shifting alone leaves them untouched.
- R5: A clock with `load` high copies each cell's stage into its live word, visible after that edge. The word layout is: bit 12 management select, 11 stored output-disable, 10 hold-over, 9 input disable, 8 input buffer mode, 7 analog enable, 6 analog select, 5 analog polarity, 4 slow slew, 3 trip select, 2:0 drive mode.
- R6: A bitstream for the whole chain is sent as the last cell's word first and cell 0's word last, each word most-significant bit first.
- R7: With management select 1 and the pad's `mgmt_oeb` bit 0, `pad_out` follows `mgmt_out` and `pad_oeb` is 0.
- R8: With management select 1 and the pad's `mgmt_oeb` bit 1, `pad_out` follows `mgmt_out` and `pad_oeb` equals the stored output-disable bit.
- R9: With management select 0, `pad_out` follows `user_out` and `pad_oeb` follows `user_oeb`.
- R10: `user_in` and `mgmt_in` both equal `pad_in` in every mode.
- R11: Reset after a load returns every pad to its defaults.
- R12: On a clock with both `rst_n` low and `load` high, reset wins: live words and stages take their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial/configuration clock |
| rst_n | input | 1 | Synchronous active-low reset to defaults |
| shift_en | input | 1 | Advance the serial chain one bit |
| load | input | 1 | Copy every serial stage into its live word |
| ser_in | input | 1 | Serial data into cell 0 |
| ser_out | output | 1 | Serial data out of the last cell |
| mgmt_out | input | NUM_PADS | Management output data per pad |
| mgmt_oeb | input | NUM_PADS | Management output disable per pad (1 = defer to configuration) |
| mgmt_in | output | NUM_PADS | Pad input returned to management |
| user_out | input | NUM_PADS | User output data per pad |
| user_oeb | input | NUM_PADS | User output disable per pad |
| user_in | output | NUM_PADS | Pad input returned to user |
| pad_in | input | NUM_PADS | Data received from the pads |
| pad_out | output | NUM_PADS | Data driven to the pads |
| pad_oeb | output | NUM_PADS | Pad output disable |
| pad_dm | output | 3*NUM_PADS | Drive mode, 3 bits per pad, pad i at [3i+2:3i] |
| pad_in_dis | output | NUM_PADS | Input disable |
| pad_ib_mode | output | NUM_PADS | Input buffer mode select |
| pad_vtrip | output | NUM_PADS | Trip-point select |
| pad_slow | output | NUM_PADS | Slow slew select |
| pad_holdover | output | NUM_PADS | Hold-over |
| pad_ana_en | output | NUM_PADS | Analog enable |
| pad_ana_sel | output | NUM_PADS | Analog select |
| pad_ana_pol | output | NUM_PADS | Analog polarity |

## Verification
The bench watches `ser_out` through a whole-chain shift and expects the default words to leave in last-cell-first order, with exactly one word of delay per cell. A cell that skipped or doubled a bit, or shifted in the wrong direction, would put the wrong bit at the boundary between words. It checks that the pad controls stay at their old values for all 39 shift clocks. A design that fed the stage straight to the pads would flicker and show partial words. The bench drives the management output-enable both active and inactive on pads whose stored bit differs, and catches a mux that ignores the stored bit or the management request. Finally it applies reset together with load. A load that took priority over reset would leave the shifted words in place.

// File: rtl/padcfg_pkg.sv
// padcfg_pkg: shared layout of one pad's configuration word.
// Assumes the serial order is fixed: bit 12 leaves a cell first.
package padcfg_pkg;

    localparam int CFG_W = 13;
    localparam int DM_W  = 3;

    // Packed so that member order equals bit order, MSB first.
    typedef struct packed {
        logic            mgmt_sel;  // 12: 1 = management drives the pad
        logic            oe_n;      // 11: stored output disable
        logic            hold;      // 10
        logic            in_dis;    // 9
        logic            ib_mode;   // 8
        logic            ana_en;    // 7
        logic            ana_sel;   // 6
        logic            ana_pol;   // 5
        logic            slow;      // 4
        logic            trip;      // 3
        logic [DM_W-1:0] drive;     // 2:0
    } pad_cfg_t;

    // Build a reset word from the per-instance choices.
    function automatic pad_cfg_t cfg_default(input logic [DM_W-1:0] dm,
                                             input logic oe_n,
                                             input logic mgmt);
        pad_cfg_t c;
        c          = '0;
        c.mgmt_sel = mgmt;
        c.oe_n     = oe_n;
        c.drive    = dm;
        return c;
    endfunction

endpackage

// File: rtl/padcfg_shift.sv
// padcfg_shift: one cell's serial stage.
// Shifts toward the MSB when enabled; the MSB is the serial output,
// so each stage adds exactly W clocks of delay. Reset loads the
// instance default so an immediate load keeps the pad at defaults.
module padcfg_shift #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] rst_word,
    input  logic         sdi,
    output logic [W-1:0] word,
    output logic         sdo
);

    logic [W-1:0] stage_q;

    // Shift register: reset to default, else shift one place when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= rst_word;
        end else if (shift_en) begin
            stage_q <= {stage_q[W-2:0], sdi};
        end
    end

    assign word = stage_q;
    assign sdo  = stage_q[W-1];

endmodule

// File: rtl/padcfg_hold.sv
// padcfg_hold: the live configuration word of one cell.
// Takes the serial stage only on load; reset has priority over load.
module padcfg_hold
    import padcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  pad_cfg_t rst_word,
    input  pad_cfg_t next_word,
    output pad_cfg_t cfg
);

    pad_cfg_t cfg_q;

    // Live word: default on reset, copy of the stage on load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= rst_word;
        end else if (load) begin
            cfg_q <= next_word;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/padcfg_route.sv
// padcfg_route: selects which side drives the pad.
// Management side: an inactive (1) output-enable request defers to the
// stored output disable; an active (0) request enables the driver.
// Pad input always fans out to both sides.
module padcfg_route (
    input  logic mgmt_sel,
    input  logic cfg_oe_n,
    input  logic mgmt_out,
    input  logic mgmt_oeb,
    input  logic user_out,
    input  logic user_oeb,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oeb,
    output logic user_in,
    output logic mgmt_in
);

    // Output mux: data and enable from the selected side.
    always_comb begin
        if (mgmt_sel) begin
            pad_out = mgmt_out;
            pad_oeb = mgmt_oeb ? cfg_oe_n : 1'b0;
        end else begin
            pad_out = user_out;
            pad_oeb = user_oeb;
        end
    end

    assign user_in = pad_in;
    assign mgmt_in = pad_in;

endmodule

// File: rtl/padcfg_cell.sv
// padcfg_cell: one pad's configuration cell (stage, live word, routing).
// Defaults are per instance, fixed at elaboration.
module padcfg_cell
    import padcfg_pkg::*;
#(
    parameter logic [DM_W-1:0] DEF_DM   = 3'b001,
    parameter logic            DEF_OEN  = 1'b1,
    parameter logic            DEF_MGMT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            load,
    input  logic            sdi,
    output logic            sdo,
    input  logic            mgmt_out,
    input  logic            mgmt_oeb,
    output logic            mgmt_in,
    input  logic            user_out,
    input  logic            user_oeb,
    output logic            user_in,
    input  logic            pad_in,
    output logic            pad_out,
    output logic            pad_oeb,
    output logic [DM_W-1:0] pad_dm,
    output logic            pad_in_dis,
    output logic            pad_ib_mode,
    output logic            pad_vtrip,
    output logic            pad_slow,
    output logic            pad_holdover,
    output logic            pad_ana_en,
    output logic            pad_ana_sel,
    output logic            pad_ana_pol
);

    localparam pad_cfg_t DEF_WORD = cfg_default(DEF_DM, DEF_OEN, DEF_MGMT);

    logic [CFG_W-1:0] stage_w;
    pad_cfg_t         live_w;

    padcfg_shift #(.W(CFG_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .rst_word (DEF_WORD),
        .sdi      (sdi),
        .word     (stage_w),
        .sdo      (sdo)
    );

    padcfg_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .rst_word  (DEF_WORD),
        .next_word (pad_cfg_t'(stage_w)),
        .cfg       (live_w)
    );

    padcfg_route u_route (
        .mgmt_sel (live_w.mgmt_sel),
        .cfg_oe_n (live_w.oe_n),
        .mgmt_out (mgmt_out),
        .mgmt_oeb (mgmt_oeb),
        .user_out (user_out),
        .user_oeb (user_oeb),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oeb  (pad_oeb),
        .user_in  (user_in),
        .mgmt_in  (mgmt_in)
    );

    // Pad control fan-out from the live word.
    assign pad_dm       = live_w.drive;
    assign pad_in_dis   = live_w.in_dis;
    assign pad_ib_mode  = live_w.ib_mode;
    assign pad_vtrip    = live_w.trip;
    assign pad_slow     = live_w.slow;
    assign pad_holdover = live_w.hold;
    assign pad_ana_en   = live_w.ana_en;
    assign pad_ana_sel  = live_w.ana_sel;
    assign pad_ana_pol  = live_w.ana_pol;

endmodule

// File: rtl/padcfg_chain.sv
// padcfg_chain: NUM_PADS configuration cells on one serial chain.
// Cell 0 takes ser_in; the last cell drives ser_out. Cells below
// NUM_BIDIR reset as driven outputs, the rest as inputs.
module padcfg_chain
    import padcfg_pkg::*;
#(
    parameter int              NUM_PADS   = 4,
    parameter int              NUM_BIDIR  = 2,
    parameter logic [DM_W-1:0] BIDIR_DM   = 3'b110,
    parameter logic [DM_W-1:0] INPUT_DM   = 3'b001,
    parameter logic            RESET_MGMT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     load,
    input  logic                     ser_in,
    output logic                     ser_out,
    input  logic [NUM_PADS-1:0]      mgmt_out,
    input  logic [NUM_PADS-1:0]      mgmt_oeb,
    output logic [NUM_PADS-1:0]      mgmt_in,
    input  logic [NUM_PADS-1:0]      user_out,
    input  logic [NUM_PADS-1:0]      user_oeb,
    output logic [NUM_PADS-1:0]      user_in,
    input  logic [NUM_PADS-1:0]      pad_in,
    output logic [NUM_PADS-1:0]      pad_out,
    output logic [NUM_PADS-1:0]      pad_oeb,
    output logic [DM_W*NUM_PADS-1:0] pad_dm,
    output logic [NUM_PADS-1:0]      pad_in_dis,
    output logic [NUM_PADS-1:0]      pad_ib_mode,
    output logic [NUM_PADS-1:0]      pad_vtrip,
    output logic [NUM_PADS-1:0]      pad_slow,
    output logic [NUM_PADS-1:0]      pad_holdover,
    output logic [NUM_PADS-1:0]      pad_ana_en,
    output logic [NUM_PADS-1:0]      pad_ana_sel,
    output logic [NUM_PADS-1:0]      pad_ana_pol
);

    logic [NUM_PADS:0] link;

    assign link[0] = ser_in;

    // One cell per pad; defaults chosen by position in the chain.
    for (genvar g = 0; g < NUM_PADS; g++) begin : g_cell
        localparam logic [DM_W-1:0] CELL_DM  = (g < NUM_BIDIR) ? BIDIR_DM : INPUT_DM;
        localparam logic            CELL_OEN = (g < NUM_BIDIR) ? 1'b0 : 1'b1;

        padcfg_cell #(
            .DEF_DM   (CELL_DM),
            .DEF_OEN  (CELL_OEN),
            .DEF_MGMT (RESET_MGMT)
        ) u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .shift_en     (shift_en),
            .load         (load),
            .sdi          (link[g]),
            .sdo          (link[g+1]),
            .mgmt_out     (mgmt_out[g]),
            .mgmt_oeb     (mgmt_oeb[g]),
            .mgmt_in      (mgmt_in[g]),
            .user_out     (user_out[g]),
            .user_oeb     (user_oeb[g]),
            .user_in      (user_in[g]),
            .pad_in       (pad_in[g]),
            .pad_out      (pad_out[g]),
            .pad_oeb      (pad_oeb[g]),
            .pad_dm       (pad_dm[DM_W*g +: DM_W]),
            .pad_in_dis   (pad_in_dis[g]),
            .pad_ib_mode  (pad_ib_mode[g]),
            .pad_vtrip    (pad_vtrip[g]),
            .pad_slow     (pad_slow[g]),
            .pad_holdover (pad_holdover[g]),
            .pad_ana_en   (pad_ana_en[g]),
            .pad_ana_sel  (pad_ana_sel[g]),
            .pad_ana_pol  (pad_ana_pol[g])
        );
    end

    assign ser_out = link[NUM_PADS];

endmodule

// File: rtl/padcfg_chain_chk.sv
// padcfg_chain_chk: temporal checks on the chain's ports, bound to the top.
module padcfg_chain_chk
    import padcfg_pkg::*;
#(
    parameter int              NUM_PADS  = 4,
    parameter int              NUM_BIDIR = 2,
    parameter logic [DM_W-1:0] BIDIR_DM  = 3'b110,
    parameter logic [DM_W-1:0] INPUT_DM  = 3'b001
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     shift_en,
    input logic                     load,
    input logic                     ser_out,
    input logic [NUM_PADS-1:0]      pad_in,
    input logic [NUM_PADS-1:0]      user_in,
    input logic [NUM_PADS-1:0]      mgmt_in,
    input logic [DM_W*NUM_PADS-1:0] pad_dm,
    input logic [NUM_PADS-1:0]      pad_in_dis,
    input logic [NUM_PADS-1:0]      pad_ib_mode,
    input logic [NUM_PADS-1:0]      pad_vtrip,
    input logic [NUM_PADS-1:0]      pad_slow,
    input logic [NUM_PADS-1:0]      pad_holdover,
    input logic [NUM_PADS-1:0]      pad_ana_en,
    input logic [NUM_PADS-1:0]      pad_ana_sel,
    input logic [NUM_PADS-1:0]      pad_ana_pol
);

    // Expected drive-mode vector after reset, built independently.
    function automatic logic [DM_W*NUM_PADS-1:0] dm_defaults();
        logic [DM_W*NUM_PADS-1:0] v;
        for (int i = 0; i < NUM_PADS; i++) begin
            v[DM_W*i +: DM_W] = (i < NUM_BIDIR) ? BIDIR_DM : INPUT_DM;
        end
        return v;
    endfunction

    localparam logic [DM_W*NUM_PADS-1:0] DM_DEF = dm_defaults();

    logic after_rst_q;

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        after_rst_q <= !rst_n;
    end

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst_q |-> (pad_dm == DM_DEF) && (pad_in_dis == '0) && (pad_ib_mode == '0)
                        && (pad_vtrip == '0) && (pad_slow == '0) && (pad_holdover == '0)
                        && (pad_ana_en == '0) && (pad_ana_sel == '0) && (pad_ana_pol == '0))
        else $error("R1 pad controls not at defaults after reset");

    assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ser_out))
        else $error("R3 serial output moved without shift enable");

    assert_controls_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pad_dm) && $stable(pad_in_dis) && $stable(pad_ib_mode)
                  && $stable(pad_vtrip) && $stable(pad_slow) && $stable(pad_holdover)
                  && $stable(pad_ana_en) && $stable(pad_ana_sel) && $stable(pad_ana_pol))
        else $error("R4 pad controls changed without load");

    assert_input_fanout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (user_in == pad_in) && (mgmt_in == pad_in))
        else $error("R10 pad input not returned to both sides");

endmodule

bind padcfg_chain padcfg_chain_chk #(
    .NUM_PADS  (NUM_PADS),
    .NUM_BIDIR (NUM_BIDIR),
    .BIDIR_DM  (BIDIR_DM),
    .INPUT_DM  (INPUT_DM)
) u_chk (.*);

// File: tb/sim_padcfg_chain.sv
// sim_padcfg_chain: self-checking bench for a three-pad chain.
module sim_padcfg_chain;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n, shift_en, load, ser_in;
    logic         ser_out;
    logic [N-1:0] mgmt_out, mgmt_oeb, mgmt_in, user_out, user_oeb, user_in;
    logic [N-1:0] pad_in, pad_out, pad_oeb;
    logic [3*N-1:0] pad_dm;
    logic [N-1:0] pad_in_dis, pad_ib_mode, pad_vtrip, pad_slow, pad_holdover;
    logic [N-1:0] pad_ana_en, pad_ana_sel, pad_ana_pol;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    padcfg_chain #(.NUM_PADS(N), .NUM_BIDIR(2)) u0 (.*);

    // Words per R5 layout: {mgmt, oe_n, hold, in_dis, ib, ana_en, ana_sel, ana_pol, slow, trip, dm[2:0]}
    localparam logic [12:0] D_BI = 13'b1_0_0000_0000_110;  // R1 bidir default
    localparam logic [12:0] D_IN = 13'b1_1_0000_0000_001;  // R1 input default
    localparam logic [12:0] W0   = 13'b0_1_1010_1010_011;  // user mode
    localparam logic [12:0] W1   = 13'b1_1_0101_0101_101;  // mgmt, stored disable 1
    localparam logic [12:0] W2   = 13'b1_0_1111_1111_010;  // mgmt, stored disable 0
    localparam logic [38:0] NEW_STREAM = {W2, W1, W0};     // R6: last cell first
    localparam logic [38:0] OLD_STREAM = {D_IN, D_BI, D_BI};

    // Routing vectors: {mgmt_out, mgmt_oeb, user_out, user_oeb, pad_in, exp pad_out, exp pad_oeb}
    localparam logic [20:0] ROUTE_TAB [4] = '{
        {3'b101, 3'b111, 3'b010, 3'b000, 3'b110, 3'b100, 3'b010},
        {3'b010, 3'b000, 3'b101, 3'b111, 3'b001, 3'b011, 3'b001},
        {3'b111, 3'b010, 3'b000, 3'b101, 3'b111, 3'b110, 3'b011},
        {3'b000, 3'b101, 3'b111, 3'b010, 3'b010, 3'b001, 3'b000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Observed control bits 10:0 of pad i, same layout as the word.
    function automatic logic [10:0] obs(input int i);
        return {pad_holdover[i], pad_in_dis[i], pad_ib_mode[i], pad_ana_en[i],
                pad_ana_sel[i], pad_ana_pol[i], pad_slow[i], pad_vtrip[i], pad_dm[3*i +: 3]};
    endfunction

    task automatic check_words(input string req, input logic [12:0] w2,
                               input logic [12:0] w1, input logic [12:0] w0);
        check(req, 32'(obs(0)), 32'(w0[10:0]));
        check(req, 32'(obs(1)), 32'(w1[10:0]));
        check(req, 32'(obs(2)), 32'(w2[10:0]));
    endtask

    // Shift 39 bits in, checking the bit leaving the chain before each edge.
    task automatic shift_all(input logic [38:0] bits, input logic [38:0] expect_out, input bit chk_out);
        for (int k = 38; k >= 0; k--) begin
            if (chk_out) check("R2 serial out", 32'(ser_out), 32'(expect_out[k]));
            ser_in   = bits[k];
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; shift_en = 1'b0; load = 1'b0; ser_in = 1'b0;
        mgmt_out = 3'b101; mgmt_oeb = 3'b111; user_out = 3'b010; user_oeb = 3'b000;
        pad_in = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset defaults, mgmt routing with deferred enable (R8)
        check_words("R1 defaults", D_IN, D_BI, D_BI);
        check("R1 mgmt select default", 32'(pad_out), 32'(3'b101));
        check("R1/R8 stored oeb defaults", 32'(pad_oeb), 32'(3'b100));

        // R2/R6: shift new stream; old words leave last cell first; R4 hold during shift
        shift_all(NEW_STREAM, OLD_STREAM, 1'b1);
        check("R2 first new bit at chain end", 32'(ser_out), 32'(W2[12]));
        check_words("R4 no change before load", D_IN, D_BI, D_BI);

        // R5/R6: load
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check_words("R5/R6 loaded words", W2, W1, W0);

        // R7 R8 R9 R10: routing table
        foreach (ROUTE_TAB[v]) begin
            {mgmt_out, mgmt_oeb, user_out, user_oeb, pad_in} = ROUTE_TAB[v][20:6];
            #1;
            check("R7/R9 pad_out", 32'(pad_out), 32'(ROUTE_TAB[v][5:3]));
            check("R7/R8/R9 pad_oeb", 32'(pad_oeb), 32'(ROUTE_TAB[v][2:0]));
            check("R10 user_in", 32'(user_in), 32'(pad_in));
            check("R10 mgmt_in", 32'(mgmt_in), 32'(pad_in));
            @(negedge clk);
        end

        // R3: ser_in toggles without shift enable
        for (int k = 0; k < 6; k++) begin
            ser_in = k[0];
            @(negedge clk);
            check("R3 ser_out held", 32'(ser_out), 32'(W2[12]));
        end
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check_words("R3 stages unchanged", W2, W1, W0);

        // R11: reset after load
        mgmt_out = 3'b011; mgmt_oeb = 3'b111;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_words("R11 revert", D_IN, D_BI, D_BI);
        check("R11 mgmt select restored", 32'(pad_out), 32'(3'b011));
        check("R11 oeb restored", 32'(pad_oeb), 32'(3'b100));

        // R12: reset together with load after a fresh shift
        shift_all(NEW_STREAM, OLD_STREAM, 1'b0);
        rst_n = 1'b0; load = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; load = 1'b0;
        check_words("R12 reset beats load", D_IN, D_BI, D_BI);
        check("R12 stage reset", 32'(ser_out), 32'(D_IN[12]));
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check_words("R1 stage defaults after reset", D_IN, D_BI, D_BI);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule